// File: doc/BRIEF.md
# Mains-Derived One-Second Prescaler

This block turns a squared, active-low waveform at mains frequency into one active-low pulse per second. It is built synchronously on a fast system clock. The mains waveform is treated as an asynchronous input: it is synchronized, and each high-to-low transition is counted as one mains cycle. A 6-bit counter counts these cycles. When the counter equals the terminal count, an equality decode sets a pulse latch. While the latch is set it forces the counter back to zero. The inverted latch output is the once-per-second clock. The next rising transition of the mains waveform releases the latch, so each pulse lasts about half a mains cycle.

The terminal count is a parameter. It is 50 for 50 Hz mains or 60 for 60 Hz mains, and it must lie in 1..63 for the 6-bit counter.

A master clear is the OR of a power-on-reset request and a user reset button. While master clear is active:
- the mains input is forced high before it reaches the synchronizer, so no cycles are seen;
- the counter and the latch are held in their idle state.

Top module: `mains_second_prescaler`

## Requirements
- R1: After rst_ni is asserted low, pps_n_o is high and the cycle count starts from zero.
- R2: A mains cycle begins at a high-to-low transition of mains_n_i. After TERM_COUNT (default 50) such transitions following reset or clear, pps_n_o goes low exactly once, within 4 system clocks of the last transition. After TERM_COUNT-1 transitions it stays high.
- R3: The pulse latch clears the counter, so every further group of TERM_COUNT mains cycles yields exactly one more pulse.
- R4: pps_n_o stays low until the next low-to-high transition of mains_n_i. The low time is the mains half period minus one system clock (tolerance of one clock).
- R5: While master clear is active, pps_n_o stays high and no mains cycles are counted, however many cycles arrive.
- R6: Master clear is the OR of por_req_i and user_rst_i (both active high). Either input alone clears the block.
- R7: After master clear is released, counting restarts from zero. A full TERM_COUNT cycles are needed for the next pulse, whatever count was reached before the clear.
- R8: A master clear asserted while pps_n_o is low returns pps_n_o high within 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mains_n_i | input | 1 | Squared mains waveform, active low, asynchronous |
| por_req_i | input | 1 | Power-on-reset request, active high |
| user_rst_i | input | 1 | User reset button, active high |
| pps_n_o | output | 1 | Once-per-second pulse, active low |

## Verification
The bench counts the pulse boundary exactly. It checks that cycle TERM_COUNT-1 gives no pulse and cycle TERM_COUNT gives one:
- an off-by-one decode would fire a cycle early or late;
- a latch that does not clear the counter would give no second pulse.

The pulse width is measured against the half period, which exposes a latch released by the wrong mains edge. A clear is applied mid-count through each clear input in turn, with cycles still arriving. This catches a design that keeps counting under clear, ignores one clear input, or resumes from the old count.

A clear during a live pulse must end that pulse promptly.

// File: rtl/msp_pkg.sv
package msp_pkg;
  localparam int unsigned MSP_CNT_W      = 6;
  localparam int unsigned MSP_SYNC_DEPTH = 2;
  localparam int unsigned MSP_TERM_50HZ  = 50;
  localparam int unsigned MSP_TERM_60HZ  = 60;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10
  } mains_edge_e;
endpackage

// File: rtl/msp_sync.sv
module msp_sync #(
  parameter int unsigned DEPTH     = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [DEPTH-1:0] stage_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= RESET_VAL;
          else         stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RESET_VAL;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/msp_clear_combiner.sv
module msp_clear_combiner #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_req_i,
  input  logic user_rst_i,
  input  logic mains_n_i,
  output logic mains_gated_o,
  output logic clear_o
);
  logic clear_raw;

  assign clear_raw = por_req_i | user_rst_i;
  // Force the mains level idle-high ahead of the synchronizer while clear is requested.
  assign mains_gated_o = mains_n_i | clear_raw;

  msp_sync #(.DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) u_clear_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(clear_raw),
    .sync_o (clear_o)
  );
endmodule

// File: rtl/msp_mains_edges.sv
module msp_mains_edges
  import msp_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mains_gated_i,
  output mains_edge_e edge_o
);
  logic level_s, level_q;

  msp_sync #(.DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) u_mains_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(mains_gated_i),
    .sync_o (level_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b1;
    else         level_q <= level_s;
  end

  always_comb begin
    edge_o = EDGE_NONE;
    if (level_q && !level_s)      edge_o = EDGE_FALL;
    else if (!level_q && level_s) edge_o = EDGE_RISE;
  end
endmodule

// File: rtl/msp_div_counter.sv
module msp_div_counter #(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned TERM_COUNT = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             hold_zero_i,
  input  logic             count_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_COUNT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i || hold_zero_i) cnt_q <= '0;
    else if (count_en_i)             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign term_o = (cnt_q == TERM_V);
endmodule

// File: rtl/msp_pulse_latch.sv
module msp_pulse_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic release_i,
  output logic latch_o
);
  logic latch_q;

  // Priority: clear, then set, then release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= 1'b0;
    else if (clear_i)   latch_q <= 1'b0;
    else if (set_i)     latch_q <= 1'b1;
    else if (release_i) latch_q <= 1'b0;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/mains_second_prescaler.sv
module mains_second_prescaler
  import msp_pkg::*;
#(
  parameter int unsigned TERM_COUNT = MSP_TERM_50HZ,
  parameter int unsigned CNT_W      = MSP_CNT_W,
  parameter int unsigned SYNC_DEPTH = MSP_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mains_n_i,
  input  logic por_req_i,
  input  logic user_rst_i,
  output logic pps_n_o
);
  logic             mains_gated;
  logic             clear_q;
  mains_edge_e      mains_edge;
  logic [CNT_W-1:0] cnt;
  logic             term_hit;
  logic             latch_q;

  msp_clear_combiner #(.SYNC_DEPTH(SYNC_DEPTH)) u_clear (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_req_i    (por_req_i),
    .user_rst_i   (user_rst_i),
    .mains_n_i    (mains_n_i),
    .mains_gated_o(mains_gated),
    .clear_o      (clear_q)
  );

  msp_mains_edges #(.SYNC_DEPTH(SYNC_DEPTH)) u_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mains_gated_i(mains_gated),
    .edge_o       (mains_edge)
  );

  msp_div_counter #(.CNT_W(CNT_W), .TERM_COUNT(TERM_COUNT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_q),
    .hold_zero_i(latch_q),
    .count_en_i (mains_edge == EDGE_FALL),
    .cnt_o      (cnt),
    .term_o     (term_hit)
  );

  msp_pulse_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_q),
    .set_i    (term_hit),
    .release_i(mains_edge == EDGE_RISE),
    .latch_o  (latch_q)
  );

  assign pps_n_o = ~latch_q;
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned TERM_COUNT = 50
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_q,
  input logic [CNT_W-1:0] cnt,
  input logic             latch_q,
  input logic             term_hit,
  input logic [1:0]       mains_edge,
  input logic             pps_n_o
);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_COUNT);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= TERM_V);

  assert_pulse_from_term_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pps_n_o) |-> $past(cnt) == TERM_V);

  assert_latch_zeroes_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q |=> cnt == '0);

  assert_release_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && mains_edge == 2'b10 && !term_hit && !clear_q) |=> pps_n_o);

  assert_clear_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_q |=> (pps_n_o && cnt == '0));
endmodule

bind mains_second_prescaler msp_checker #(.CNT_W(CNT_W), .TERM_COUNT(TERM_COUNT)) u_msp_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_q   (clear_q),
  .cnt       (cnt),
  .latch_q   (latch_q),
  .term_hit  (term_hit),
  .mains_edge(mains_edge),
  .pps_n_o   (pps_n_o)
);

// File: tb/mains_second_prescaler_tb_top.sv
module mains_second_prescaler_tb_top;
  localparam int TERM = 50;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mains_n = 1'b1;
  logic por_req = 1'b0;
  logic user_rst = 1'b0;
  logic pps_n;

  int tests_run = 0;
  int tests_failed = 0;
  int pulses = 0;
  int low_run = 0;
  int last_width = 0;
  logic pps_prev = 1'b1;
  int cycles = 0;

  always #5 clk = ~clk;

  mains_second_prescaler #(.TERM_COUNT(TERM)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .mains_n_i (mains_n),
    .por_req_i (por_req),
    .user_rst_i(user_rst),
    .pps_n_o   (pps_n)
  );

  always @(negedge clk) begin
    if (pps_prev && !pps_n) pulses++;
    if (!pps_n) low_run++;
    if (!pps_prev && pps_n) begin
      last_width = low_run;
      low_run = 0;
    end
    pps_prev = pps_n;
  end

  task automatic check(input string req, input int actual, input int expected);
    tests_run++;
    if (actual != expected) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mains_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      mains_n = 1'b0;
      wait_clks(HALF);
      mains_n = 1'b1;
      wait_clks(HALF);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(4);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 pps high after reset", int'(pps_n), 1);
  endtask

  task automatic t_boundary();
    int p0;
    p0 = pulses;
    mains_cycles(TERM - 1);
    check("R2 no pulse after TERM-1 cycles", pulses - p0, 0);
    mains_n = 1'b0;
    wait_clks(5);
    check("R2 pulse low within 4 clocks of last fall", int'(pps_n), 0);
    wait_clks(HALF - 5);
    mains_n = 1'b1;
    wait_clks(HALF);
    check("R2 exactly one pulse after TERM cycles", pulses - p0, 1);
    check("R4 pulse width near half period", int'(last_width >= HALF - 2 && last_width <= HALF), 1);
  endtask

  task automatic t_periodic();
    int p0;
    p0 = pulses;
    mains_cycles(TERM - 1);
    check("R3 counter restarted after pulse", pulses - p0, 0);
    mains_cycles(1);
    check("R3 second pulse after next TERM cycles", pulses - p0, 1);
    mains_cycles(2 * TERM);
    check("R3 two pulses over 2*TERM cycles", pulses - p0, 3);
  endtask

  task automatic t_clear(input bit use_por, input string req);
    int p0;
    mains_cycles(30);
    if (use_por) por_req = 1'b1; else user_rst = 1'b1;
    wait_clks(4);
    p0 = pulses;
    mains_cycles(TERM + 10);
    check({"R5 no pulse during clear via ", req}, pulses - p0, 0);
    check({"R5 pps high during clear via ", req}, int'(pps_n), 1);
    por_req = 1'b0;
    user_rst = 1'b0;
    wait_clks(5);
    mains_cycles(TERM - 1);
    check({"R7 count restarts from zero, ", req}, pulses - p0, 0);
    mains_cycles(1);
    check({"R7 pulse after full TERM post clear, ", req}, pulses - p0, 1);
  endtask

  task automatic t_clear_in_pulse();
    mains_cycles(TERM - 1);
    mains_n = 1'b0;
    wait_clks(6);
    check("R8 pulse active before clear", int'(pps_n), 0);
    user_rst = 1'b1;
    wait_clks(4);
    check("R8 clear ends pulse within 4 clocks", int'(pps_n), 1);
    mains_n = 1'b1;
    wait_clks(HALF);
    user_rst = 1'b0;
    wait_clks(5);
  endtask

  task automatic t_async_reset_mid();
    int p0;
    mains_cycles(20);
    do_reset();
    check("R1 pps high after mid-count reset", int'(pps_n), 1);
    p0 = pulses;
    mains_cycles(TERM - 1);
    check("R1 count from zero after reset", pulses - p0, 0);
    mains_cycles(1);
    check("R1 pulse after TERM cycles post reset", pulses - p0, 1);
  endtask

  initial begin
    t_reset_state();
    t_boundary();
    t_periodic();
    t_clear(1'b0, "R6 user button");
    t_clear(1'b1, "R6 power-on request");
    t_clear_in_pulse();
    t_async_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule